// File: doc/BRIEF.md
# Rotating Priority Interrupt Bus Arbiter

This block decides which of several interrupt-controller agents wins a delivery. Each agent has a small arbitration rank. Among the agents named in a request mask, the one with the highest rank wins. After every win the ranks rotate: the winner falls to the bottom and every other agent moves up one step. An agent that is already at the top rank instead lands one step above the winner's old rank. Over time, every agent gets served.

A delivery is started with a one-cycle strobe that carries a mask and a mode. In single mode exactly one winner is granted. In broadcast mode every masked agent is granted, one per cycle. The ranks are re-evaluated between grants, so the grant order follows the ranks as they rotate. A resync command reloads every rank from the per-agent home values, and reset does the same. The current ranks are visible on an output so that the rotation can be observed.

Top module: `irq_rot_arb`

## Requirements
- R1: A grant goes to the requested agent with the largest current rank; ranks are packed with agent i at bits [i*W +: W] of `cur_ids` and `home_ids`.
- R2: After a grant without resync, the winner's rank is 0.
- R3: After a grant, every other agent whose rank is below the all-ones value increases its rank by one, whether it was requested or not.
- R4: After a grant, every other agent whose rank is all ones takes the winner's pre-grant rank plus one, modulo 2^W.
- R5: Synchronous active-high reset loads every rank from `home_ids` and clears `grant_vld` and `done`.
- R6: When `resync` is high at a clock edge, every rank is loaded from `home_ids` at that edge. This takes precedence over the rotation of a grant at the same edge, and the grant itself is still issued.
- R7: With `mode` = 0 (single) and a non-empty mask, exactly one grant is issued, then `done`.
- R8: With `mode` = 1 (broadcast), each masked agent is granted exactly once, one per cycle, in rank order re-evaluated after each rotation.
- R9: An empty mask produces `done` with no `grant_vld` pulse.
- R10: When several requested agents share the largest rank, the lowest index wins.
- R11: The first grant appears one cycle after the edge that samples `start`. `done` is high for exactly one cycle, in the cycle after the last grant. `start` is ignored while a delivery is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a delivery (sampled when idle) |
| mode | input | 1 | 0 = single winner, 1 = broadcast to all masked agents |
| req_mask | input | N | Agents addressed by the delivery |
| resync | input | 1 | Reload all ranks from home values |
| home_ids | input | N*W | Per-agent home rank |
| grant_idx | output | $clog2(N) | Index of the agent granted this cycle |
| grant_vld | output | 1 | One-cycle pulse per grant |
| done | output | 1 | One-cycle pulse ending a delivery |
| cur_ids | output | N*W | Current ranks, packed per agent |

## Verification
Every one of the 16 request masks is run in both modes back to back, so the ranks keep evolving between runs. This separates a correct maximum pick from index-order picking, and single mode from broadcast. A long run of single grants to the lowest-ranked agent drives the other ranks into saturation and exercises the wrap rule, which a plain increment would get wrong. Duplicate home ranks expose the tie-break order. Two further cases cover a resync at the same edge as a grant and a start strobe issued mid-delivery, which distinguish precedence and ignore behaviour from naive implementations.

// File: rtl/irq_rot_arb_pkg.sv
package irq_rot_arb_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  localparam logic MODE_SINGLE = 1'b0;
  localparam logic MODE_ALL    = 1'b1;
endpackage

// File: rtl/irq_rot_pick.sv
module irq_rot_pick #(
  parameter int N     = 4,
  parameter int W     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N*W-1:0]   ids,
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] win_idx
);
  logic [W-1:0] best_id;
  logic         found;

  // Strict greater-than keeps the lowest index on equal ranks.
  always_comb begin
    win_idx = '0;
    best_id = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || ids[i*W +: W] > best_id)) begin
        found   = 1'b1;
        best_id = ids[i*W +: W];
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_rot_ids.sv
module irq_rot_ids #(
  parameter int N     = 4,
  parameter int W     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [N*W-1:0]   home,
  input  logic             upd,
  input  logic [IDX_W-1:0] win_idx,
  output logic [N*W-1:0]   ids
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] rank_q [N];
  logic [W-1:0] win_pre;

  assign win_pre = rank_q[win_idx];

  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || load) begin
        rank_q[g] <= home[g*W +: W];
      end else if (upd) begin
        if (IDX_W'(g) == win_idx)
          rank_q[g] <= '0;
        else if (rank_q[g] == TOP)
          rank_q[g] <= win_pre + W'(1);
        else
          rank_q[g] <= rank_q[g] + W'(1);
      end
    end
    assign ids[g*W +: W] = rank_q[g];
  end
endmodule

// File: rtl/irq_rot_seq.sv
module irq_rot_seq
  import irq_rot_arb_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [N-1:0]     req_mask,
  input  logic [IDX_W-1:0] win_idx,
  output logic [N-1:0]     pend_q,
  output logic             grant,
  output logic [IDX_W-1:0] grant_idx_q,
  output logic             grant_vld_q,
  output logic             done_q
);
  seq_state_t state_q;
  logic       all_q;

  assign grant = (state_q == SEQ_RUN) && (pend_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SEQ_IDLE;
      all_q       <= MODE_SINGLE;
      pend_q      <= '0;
      grant_idx_q <= '0;
      grant_vld_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      grant_vld_q <= 1'b0;
      done_q      <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            pend_q  <= req_mask;
            all_q   <= mode;
            state_q <= SEQ_RUN;
          end
        end
        default: begin
          if (grant) begin
            grant_vld_q <= 1'b1;
            grant_idx_q <= win_idx;
            if (all_q == MODE_ALL)
              pend_q <= pend_q & ~(N'(1) << win_idx);
            else
              pend_q <= '0;
          end else begin
            done_q  <= 1'b1;
            state_q <= SEQ_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_rot_arb.sv
module irq_rot_arb #(
  parameter int N     = 4,
  parameter int W     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [N-1:0]     req_mask,
  input  logic             resync,
  input  logic [N*W-1:0]   home_ids,
  output logic [IDX_W-1:0] grant_idx,
  output logic             grant_vld,
  output logic             done,
  output logic [N*W-1:0]   cur_ids
);
  logic [N-1:0]     pend_q;
  logic [IDX_W-1:0] win_idx;
  logic             grant;

  irq_rot_pick #(.N(N), .W(W), .IDX_W(IDX_W)) u_pick (
    .ids     (cur_ids),
    .req     (pend_q),
    .win_idx (win_idx)
  );

  irq_rot_seq #(.N(N), .IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .mode        (mode),
    .req_mask    (req_mask),
    .win_idx     (win_idx),
    .pend_q      (pend_q),
    .grant       (grant),
    .grant_idx_q (grant_idx),
    .grant_vld_q (grant_vld),
    .done_q      (done)
  );

  irq_rot_ids #(.N(N), .W(W), .IDX_W(IDX_W)) u_ids (
    .clk     (clk),
    .rst     (rst),
    .load    (resync),
    .home    (home_ids),
    .upd     (grant),
    .win_idx (win_idx),
    .ids     (cur_ids)
  );
endmodule

// File: rtl/irq_rot_arb_chk.sv
module irq_rot_arb_chk #(
  parameter int N     = 4,
  parameter int W     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst,
  input logic             resync,
  input logic [N*W-1:0]   home_ids,
  input logic [N*W-1:0]   cur_ids,
  input logic [IDX_W-1:0] grant_idx,
  input logic             grant_vld,
  input logic             done,
  input logic [N-1:0]     pend_q
);
  logic [N-1:0]   pend_prev;
  logic           resync_prev;
  logic [N*W-1:0] home_prev;
  logic [W-1:0]   win_rank;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_prev   <= '0;
      resync_prev <= 1'b0;
      home_prev   <= '0;
    end else begin
      pend_prev   <= pend_q;
      resync_prev <= resync;
      home_prev   <= home_ids;
    end
  end

  assign win_rank = cur_ids[grant_idx*W +: W];

  AST_GRANT_WAS_PENDING: assert property (@(posedge clk) disable iff (rst)
    grant_vld |-> pend_prev[grant_idx]); // R1

  AST_WINNER_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && !resync_prev) |-> (win_rank == '0)); // R2

  AST_RESYNC_RELOAD: assert property (@(posedge clk) disable iff (rst)
    resync_prev |-> (cur_ids == home_prev)); // R6

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_DONE_NOT_WITH_GRANT: assert property (@(posedge clk) disable iff (rst)
    !(done && grant_vld)); // R9
endmodule

bind irq_rot_arb irq_rot_arb_chk #(.N(N), .W(W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .resync    (resync),
  .home_ids  (home_ids),
  .cur_ids   (cur_ids),
  .grant_idx (grant_idx),
  .grant_vld (grant_vld),
  .done      (done),
  .pend_q    (pend_q)
);

// File: tb/irq_rot_arb_tb.sv
module irq_rot_arb_tb;
  localparam int N      = 4;
  localparam int W      = 4;
  localparam int IDX_W  = 2;
  localparam int CLK_NS = 10;

  logic             clk = 1'b0;
  logic             rst, start, mode, resync;
  logic [N-1:0]     req_mask;
  logic [N*W-1:0]   home_ids;
  logic [IDX_W-1:0] grant_idx;
  logic             grant_vld, done;
  logic [N*W-1:0]   cur_ids;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  int ids [N];

  always #(CLK_NS/2) clk = ~clk;

  irq_rot_arb #(.N(N), .W(W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .req_mask(req_mask),
    .resync(resync), .home_ids(home_ids), .grant_idx(grant_idx),
    .grant_vld(grant_vld), .done(done), .cur_ids(cur_ids)
  );

  function automatic logic [N*W-1:0] pack_ids();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(ids[i]);
    return v;
  endfunction

  task automatic load_home();
    for (int i = 0; i < N; i++) ids[i] = int'(home_ids[i*W +: W]);
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_resync();
    @(negedge clk) resync = 1'b1;
    @(negedge clk) resync = 1'b0;
    load_home();
    check("R6 resync ranks", 64'(cur_ids), 64'(pack_ids()));
  endtask

  // One delivery; poke = strobe start mid-delivery, rs = resync at the first grant edge.
  task automatic run_op(logic [N-1:0] m, logic md, bit poke, bit rs);
    logic [N-1:0] pend;
    bit first;
    @(negedge clk);
    start = 1'b1; req_mask = m; mode = md;
    @(negedge clk);
    start = 1'b0;
    if (rs) resync = 1'b1;
    pend = m;
    first = 1;
    for (int it = 0; it <= N; it++) begin
      int w, pre, best;
      bit tie, sat;
      @(negedge clk);
      resync = 1'b0;
      start = (poke && first) ? 1'b1 : 1'b0;
      if (poke && first) begin req_mask = 4'b0001; mode = 1'b0; end
      if (pend == '0) begin
        check(md ? "R8 done after last" : (m == '0 ? "R9 empty done" : "R7 single done"),
              64'(done), 64'd1);
        check("R11 no grant with done", 64'(grant_vld), 64'd0);
        break;
      end
      w = -1; best = -1; tie = 0;
      for (int i = 0; i < N; i++)
        if (pend[i]) begin
          if (ids[i] > best) begin best = ids[i]; w = i; tie = 0; end
          else if (ids[i] == best) tie = 1;
        end
      check("R11 grant pulse", 64'(grant_vld), 64'd1);
      check(tie ? "R10 tie winner" : "R1 winner", 64'(grant_idx), 64'(w));
      pre = ids[w];
      sat = 0;
      if (rs && first) begin
        load_home();
        check("R6 resync beats rotate", 64'(cur_ids), 64'(pack_ids()));
      end else begin
        for (int i = 0; i < N; i++) begin
          if (i == w) ids[i] = 0;
          else if (ids[i] == (1 << W) - 1) begin ids[i] = (pre + 1) % (1 << W); sat = 1; end
          else ids[i] = ids[i] + 1;
        end
        check(sat ? "R4 saturated rotate" : "R3 R2 rotate", 64'(cur_ids), 64'(pack_ids()));
      end
      pend = md ? (pend & ~(N'(1) << w)) : '0;
      first = 0;
    end
    if (poke) begin
      @(negedge clk);
      check("R11 start ignored while busy", 64'({grant_vld, done}), 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; mode = 1'b0; resync = 1'b0; req_mask = '0;
    for (int i = 0; i < N; i++) home_ids[i*W +: W] = W'(i);
    repeat (3) @(negedge clk);
    load_home();
    check("R5 reset ranks", 64'(cur_ids), 64'(pack_ids()));
    check("R5 reset outputs", 64'({grant_vld, done}), 64'd0);
    rst = 1'b0;

    for (int md = 0; md < 2; md++)
      for (int m = 0; m < (1 << N); m++)
        run_op(N'(m), md[0], 0, 0);

    do_resync();
    for (int k = 0; k < 16; k++) run_op(4'b0001, 1'b0, 0, 0);

    home_ids = '0;
    do_resync();
    run_op(4'b1111, 1'b1, 0, 0);
    run_op(4'b0110, 1'b1, 0, 0);

    for (int i = 0; i < N; i++) home_ids[i*W +: W] = W'(i);
    do_resync();
    run_op(4'b1111, 1'b1, 1, 0);
    run_op(4'b1011, 1'b0, 0, 1);
    run_op(4'b1101, 1'b1, 0, 1);

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule